// File: doc/BRIEF.md
# Refresh-Priority Bus Arbiter with Hold Handshake

This block decides which of four sources owns a shared external bus: a DRAM refresh timer, an external bus master, a DMA engine and the CPU. Priority is fixed, with refresh on top, then the external master, then DMA, then the CPU. Ownership moves only when the bus is free or when the current owner reports the end of its bus cycle on `cycle_done`. Bus cycle timing is handled elsewhere. When nobody asks for the bus, the grant parks on the CPU, so exactly one grant bit is high at all times.

The external master uses a request/acknowledge handshake (`hold_req` / `hold_ack`). If the refresh timer asks for the bus while the master holds it, the arbiter withdraws `hold_ack`. It then waits until the master has let go of `hold_req`, and only then runs the refresh. The refresh is a dummy read that changes no stored data. After it, the arbiter keeps the bus reserved for the interrupted master for `RESUME_WINDOW` cycles. If the master asks again inside that window, `hold_ack` comes back. Otherwise normal arbitration resumes. `refresh_strobe` marks the first cycle of each refresh. `refresh_ack` tells the refresh timer that its dummy read has finished.

The controller has six states:
- `ST_IDLE`: the bus is free.
- `ST_OWNED`: DMA or the CPU is running a cycle.
- `ST_MASTER`: the bus is granted to the external master.
- `ST_ACK_DROP`: the acknowledge has been withdrawn and the master has not yet let go.
- `ST_REFRESH`: the dummy read is running.
- `ST_RETURN`: the bus is reserved for the preempted master.

The transitions are:
- ST_IDLE: arbitrates every cycle.
- ST_OWNED: arbitrates on `cycle_done`.
- ST_MASTER: goes to ST_ACK_DROP on a refresh request, or arbitrates when `hold_req` falls.
- ST_ACK_DROP: goes to ST_REFRESH once `hold_req` is seen low.
- ST_REFRESH: on `cycle_done`, goes to ST_RETURN if the refresh preempted the master, or arbitrates otherwise. The pending refresh request is masked at that edge.
- ST_RETURN: goes to ST_REFRESH on a new refresh request, to ST_MASTER on `hold_req`, or arbitrates when the window expires.

Top module: `rfsh_bus_arbiter`

## Requirements
- R1: In reset and in the first cycle after reset, `grant` is 4'b1000 (parked on the CPU), and `hold_ack`, `refresh_strobe` and `refresh_ack` are low.
- R2: Exactly one bit of `grant` is high in every cycle. Bit 0 is refresh, bit 1 is the external master, bit 2 is DMA and bit 3 is the CPU.
- R3: When the bus is free, the next grant goes to the highest-priority pending request, in the order refresh, external master, DMA, CPU. This grant is visible one clock after the request is sampled.
- R4: While DMA or the CPU owns the bus, `grant` does not change until a clock edge at which `cycle_done` is high. This holds even with a higher-priority request pending, including refresh.
- R5: A granted external master sees `hold_ack` high from the cycle after its grant for as long as it keeps `hold_req` high. `hold_ack` is high only while `grant[1]` is high. When `hold_req` falls, `hold_ack` drops one clock later and the bus is re-arbitrated.
- R6: A refresh request while `hold_ack` is high drops `hold_ack` one clock later. `grant` stays 4'b0010 until `hold_req` is sampled low.
- R7: A refresh that preempts the master starts only at the edge after `hold_req` is sampled low. `refresh_strobe` is high for exactly the first cycle of every refresh, and the refresh grant is 4'b0001.
- R8: `refresh_ack` is high exactly when the refresh grant is active and `cycle_done` is high. The request still pending at that completing edge does not start a second refresh.
- R9: After a refresh that preempted the master, `grant` stays 4'b0010 with `hold_ack` low for up to `RESUME_WINDOW` cycles. If `hold_req` is seen high in that window, `hold_ack` is reasserted one clock later, and waiting DMA or CPU requests are not served.
- R10: If the resume window expires with no `hold_req`, normal arbitration resumes at the edge ending its last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_req | input | 1 | Refresh timer request, held until `refresh_ack` |
| hold_req | input | 1 | External master bus request |
| dma_req | input | 1 | DMA bus request |
| cpu_req | input | 1 | CPU bus request |
| cycle_done | input | 1 | Current bus cycle ends at this clock edge |
| grant | output | 4 | One-hot bus grant (refresh, master, DMA, CPU from bit 0) |
| hold_ack | output | 1 | Acknowledge to the external master |
| refresh_strobe | output | 1 | First cycle of a refresh dummy read |
| refresh_ack | output | 1 | Refresh dummy read completes this cycle |

## Verification
A corrupted state or owner register shows on `grant` or `hold_ack` in the very next cycle. Examples are a grant that moves in the middle of a DMA cycle, an acknowledge left high after a refresh request, or a refresh started while the master still drives the bus. A wrong resume flag shows one clock after the refresh completes: the grant returns to normal arbitration instead of staying reserved for the master, or the reverse. An off-by-one in the resume window moves the handover to DMA or CPU by exactly one cycle, so the bench samples both edges of the window.

// File: rtl/rba_pkg.sv
package rba_pkg;
    localparam int SRC_COUNT   = 4;
    localparam int SRC_REFRESH = 0;
    localparam int SRC_EXTM    = 1;
    localparam int SRC_DMA     = 2;
    localparam int SRC_CPU     = 3;

    typedef logic [SRC_COUNT-1:0] src_vec_t;

    localparam src_vec_t PARK_VEC = src_vec_t'(1) << SRC_CPU;
    localparam src_vec_t REF_VEC  = src_vec_t'(1) << SRC_REFRESH;
    localparam src_vec_t EXTM_VEC = src_vec_t'(1) << SRC_EXTM;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OWNED,
        ST_MASTER,
        ST_ACK_DROP,
        ST_REFRESH,
        ST_RETURN
    } arb_state_e;

    // Maps an arbitration winner to the state that serves it.
    function automatic arb_state_e state_for(src_vec_t win);
        if (win[SRC_REFRESH])
            return ST_REFRESH;
        else if (win[SRC_EXTM])
            return ST_MASTER;
        else if (win[SRC_DMA] || win[SRC_CPU])
            return ST_OWNED;
        return ST_IDLE;
    endfunction

    // Owner vector for a winner; with no winner the bus parks on the CPU.
    function automatic src_vec_t owner_for(src_vec_t win);
        if (win == '0)
            return PARK_VEC;
        return win;
    endfunction
endpackage

// File: rtl/rba_prio_pick.sv
module rba_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] win
);
    // blocked[i] is high when any request with index below i is active.
    logic [N-1:0] blocked;

    for (genvar i = 0; i < N; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign blocked[i] = 1'b0;
        end else begin : g_rest
            assign blocked[i] = blocked[i-1] | req[i-1];
        end
        assign win[i] = req[i] & ~blocked[i];
    end
endmodule

// File: rtl/rba_resume_timer.sv
module rba_resume_timer #(
    parameter int WINDOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = (WINDOW < 2) ? 1 : $clog2(WINDOW);
    localparam logic [CW-1:0] START = CW'(WINDOW - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= START;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/rfsh_bus_arbiter.sv
module rfsh_bus_arbiter
    import rba_pkg::*;
#(
    parameter int RESUME_WINDOW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       refresh_req,
    input  logic       hold_req,
    input  logic       dma_req,
    input  logic       cpu_req,
    input  logic       cycle_done,
    output logic [3:0] grant,
    output logic       hold_ack,
    output logic       refresh_strobe,
    output logic       refresh_ack
);
    arb_state_e state_q, state_d;
    src_vec_t   owner_q, owner_d;
    logic       resume_q, resume_d;
    logic       first_q, first_d;

    src_vec_t   req_all, req_nref, win_all, win_nref;
    logic       win_expired, timer_load, timer_run;

    assign req_all  = {cpu_req, dma_req, hold_req, refresh_req};
    assign req_nref = {cpu_req, dma_req, hold_req, 1'b0};

    rba_prio_pick #(.N(SRC_COUNT)) pick_all_i (
        .req (req_all),
        .win (win_all)
    );

    rba_prio_pick #(.N(SRC_COUNT)) pick_nref_i (
        .req (req_nref),
        .win (win_nref)
    );

    assign timer_load = (state_d == ST_RETURN) && (state_q != ST_RETURN);
    assign timer_run  = (state_q == ST_RETURN);

    rba_resume_timer #(.WINDOW(RESUME_WINDOW)) resume_timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .run     (timer_run),
        .expired (win_expired)
    );

    // Next-state logic.
    always_comb begin
        state_d  = state_q;
        owner_d  = owner_q;
        resume_d = resume_q;
        unique case (state_q)
            ST_IDLE: begin
                state_d  = state_for(win_all);
                owner_d  = owner_for(win_all);
                resume_d = 1'b0;
            end
            ST_OWNED: begin
                if (cycle_done) begin
                    state_d  = state_for(win_all);
                    owner_d  = owner_for(win_all);
                    resume_d = 1'b0;
                end
            end
            ST_MASTER: begin
                if (refresh_req) begin
                    state_d = ST_ACK_DROP;
                end else if (!hold_req) begin
                    state_d  = state_for(win_all);
                    owner_d  = owner_for(win_all);
                    resume_d = 1'b0;
                end
            end
            ST_ACK_DROP: begin
                if (!hold_req) begin
                    state_d  = ST_REFRESH;
                    owner_d  = REF_VEC;
                    resume_d = 1'b1;
                end
            end
            ST_REFRESH: begin
                if (cycle_done) begin
                    if (resume_q) begin
                        state_d = ST_RETURN;
                        owner_d = EXTM_VEC;
                    end else begin
                        state_d  = state_for(win_nref);
                        owner_d  = owner_for(win_nref);
                        resume_d = 1'b0;
                    end
                end
            end
            ST_RETURN: begin
                if (refresh_req) begin
                    state_d  = ST_REFRESH;
                    owner_d  = REF_VEC;
                    resume_d = 1'b1;
                end else if (hold_req) begin
                    state_d  = ST_MASTER;
                    owner_d  = EXTM_VEC;
                    resume_d = 1'b0;
                end else if (win_expired) begin
                    state_d  = state_for(win_all);
                    owner_d  = owner_for(win_all);
                    resume_d = 1'b0;
                end
            end
            default: begin
                state_d  = ST_IDLE;
                owner_d  = PARK_VEC;
                resume_d = 1'b0;
            end
        endcase
        first_d = (state_d == ST_REFRESH) && (state_q != ST_REFRESH);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            owner_q  <= PARK_VEC;
            resume_q <= 1'b0;
            first_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            owner_q  <= owner_d;
            resume_q <= resume_d;
            first_q  <= first_d;
        end
    end

    // Output decode.
    always_comb begin
        grant          = owner_q;
        hold_ack       = (state_q == ST_MASTER);
        refresh_strobe = first_q;
        refresh_ack    = (state_q == ST_REFRESH) && cycle_done;
    end
endmodule

// File: rtl/rfsh_bus_arbiter_chk.sv
module rfsh_bus_arbiter_chk
    import rba_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       refresh_req,
    input logic       hold_req,
    input logic       cycle_done,
    input logic [3:0] grant,
    input logic       hold_ack,
    input logic       refresh_strobe,
    input logic       refresh_ack
);
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) == 1);  // R2

    AST_ACK_ONLY_WITH_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> grant[SRC_EXTM]);  // R5

    AST_DMA_HELD_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
        grant[SRC_DMA] && !cycle_done |=> grant[SRC_DMA]);  // R4

    AST_ACK_DROPS_FOR_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack && refresh_req |=> !hold_ack);  // R6

    AST_REFRESH_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_strobe && $past(grant[SRC_EXTM]) |-> !$past(hold_req));  // R7

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_strobe |=> !refresh_strobe);  // R7

    AST_STROBE_WITH_REF_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_strobe |-> grant[SRC_REFRESH]);  // R7

    AST_DONE_ACK_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_ack |-> grant[SRC_REFRESH] && cycle_done);  // R8
endmodule

bind rfsh_bus_arbiter rfsh_bus_arbiter_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .refresh_req    (refresh_req),
    .hold_req       (hold_req),
    .cycle_done     (cycle_done),
    .grant          (grant),
    .hold_ack       (hold_ack),
    .refresh_strobe (refresh_strobe),
    .refresh_ack    (refresh_ack)
);

// File: tb/rfsh_bus_arbiter_tb_top.sv
module rfsh_bus_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 8;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       refresh_req = 1'b0;
    logic       hold_req = 1'b0;
    logic       dma_req = 1'b0;
    logic       cpu_req = 1'b0;
    logic       cycle_done = 1'b0;
    logic [3:0] grant;
    logic       hold_ack, refresh_strobe, refresh_ack;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfsh_bus_arbiter #(.RESUME_WINDOW(WIN)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .refresh_req    (refresh_req),
        .hold_req       (hold_req),
        .dma_req        (dma_req),
        .cpu_req        (cpu_req),
        .cycle_done     (cycle_done),
        .grant          (grant),
        .hold_ack       (hold_ack),
        .refresh_strobe (refresh_strobe),
        .refresh_ack    (refresh_ack)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_grant(input logic [3:0] exp, input string tag);
        n_checks++;
        if (grant !== exp) begin
            n_fail++;
            $display("FAIL %s grant actual=%b expected=%b", tag, grant, exp);
        end
    endtask

    task automatic chk_bit(input string name, input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", tag, name, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk_grant(4'b1000, "R1 in reset");
        chk_bit("hold_ack", hold_ack, 1'b0, "R1");
        rst_n = 1'b1;
        tick();
        chk_grant(4'b1000, "R1 after reset");
        chk_bit("refresh_strobe", refresh_strobe, 1'b0, "R1");
        chk_bit("refresh_ack", refresh_ack, 1'b0, "R1");
    endtask

    task automatic t_priority();
        refresh_req = 1; hold_req = 1; dma_req = 1; cpu_req = 1;
        tick();
        chk_grant(4'b0001, "R3 refresh first");
        chk_bit("refresh_strobe", refresh_strobe, 1'b1, "R7 start");
        tick();
        chk_bit("refresh_strobe", refresh_strobe, 1'b0, "R7 pulse");
        cycle_done = 1;
        #1;
        chk_bit("refresh_ack", refresh_ack, 1'b1, "R8 ack");
        refresh_req = 0;
        tick();
        chk_grant(4'b0010, "R8 R3 master after refresh");
        cycle_done = 0;
        tick();
        chk_bit("hold_ack", hold_ack, 1'b1, "R5 ack");
        hold_req = 0;
        tick();
        chk_grant(4'b0100, "R5 R3 dma after master");
        chk_bit("hold_ack", hold_ack, 1'b0, "R5 release");
        repeat (3) tick();
        chk_grant(4'b0100, "R4 dma held");
        cycle_done = 1; dma_req = 0;
        tick();
        chk_grant(4'b1000, "R3 cpu last");
        cpu_req = 0;
        tick();
        cycle_done = 0;
        chk_grant(4'b1000, "R2 park");
    endtask

    task automatic t_refresh_waits();
        cpu_req = 1;
        tick();
        chk_grant(4'b1000, "R3 cpu owns");
        refresh_req = 1;
        repeat (2) tick();
        chk_grant(4'b1000, "R4 refresh waits");
        cycle_done = 1;
        tick();
        chk_grant(4'b0001, "R4 refresh at boundary");
        chk_bit("refresh_ack", refresh_ack, 1'b1, "R8 ack same cycle");
        refresh_req = 0;
        tick();
        chk_grant(4'b1000, "R8 no second refresh");
        chk_bit("refresh_strobe", refresh_strobe, 1'b0, "R8");
        cpu_req = 0;
        tick();
        cycle_done = 0;
    endtask

    task automatic t_hold_preempt();
        hold_req = 1;
        tick();
        chk_bit("hold_ack", hold_ack, 1'b1, "R5 granted");
        refresh_req = 1;
        tick();
        chk_bit("hold_ack", hold_ack, 1'b0, "R6 ack dropped");
        chk_grant(4'b0010, "R6 master keeps bus");
        repeat (2) tick();
        chk_grant(4'b0010, "R7 waits for release");
        chk_bit("refresh_strobe", refresh_strobe, 1'b0, "R7 no early start");
        hold_req = 0;
        tick();
        chk_grant(4'b0001, "R7 refresh after release");
        chk_bit("refresh_strobe", refresh_strobe, 1'b1, "R7");
        hold_req = 1; dma_req = 1; cycle_done = 1; refresh_req = 0;
        tick();
        cycle_done = 0;
        chk_grant(4'b0010, "R9 reserved");
        chk_bit("hold_ack", hold_ack, 1'b0, "R9");
        tick();
        chk_bit("hold_ack", hold_ack, 1'b1, "R9 ack returns");
        chk_grant(4'b0010, "R9 dma waits");
        hold_req = 0;
        tick();
        chk_grant(4'b0100, "R5 dma after master");
        dma_req = 0; cycle_done = 1;
        tick();
        cycle_done = 0;
    endtask

    task automatic t_window_expire();
        hold_req = 1;
        tick();
        refresh_req = 1;
        tick();
        hold_req = 0;
        tick();
        chk_grant(4'b0001, "R7 refresh");
        cycle_done = 1; refresh_req = 0; cpu_req = 1;
        tick();
        cycle_done = 0;
        repeat (WIN - 1) tick();
        chk_grant(4'b0010, "R9 window last cycle");
        tick();
        chk_grant(4'b1000, "R10 cpu after expiry");
        cpu_req = 0; cycle_done = 1;
        tick();
        cycle_done = 0;
        chk_grant(4'b1000, "R2 park end");
    endtask

    initial begin
        t_reset();
        t_priority();
        t_refresh_waits();
        t_hold_preempt();
        t_window_expire();
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule